// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block sits between a warp's load/store issue stage and global memory. It takes one request carrying a byte address for each of 32 lanes, an active-lane mask and an element size. It returns the smallest set of transactions that covers every byte the active lanes touch. Memory is fetched only in aligned 128-byte segments. Each transaction names one segment base and the lanes it serves. Lanes that share a segment are merged into one transaction. A lane with no neighbours still costs a full segment fetch.

Segments are found one per transaction, in lane order. The lowest-numbered lane that still needs a segment chooses the next segment. Every lane that needs that same segment rides along, and those lanes are then retired. Both sides use a valid/ready handshake, so memory can apply backpressure at any time. The block accepts a new request only after the current one has finished. It marks the end of each request with a one-cycle done pulse that carries the number of transactions produced.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, tx_valid is 0 and done is 0.
- R2: tx_base is always a multiple of 128. A lane belongs to the transaction whose base equals its byte address with the low 7 bits cleared.
- R3: When every active lane's element lies inside one aligned 128-byte segment, exactly one transaction is produced, and its lane mask equals the active mask.
- R4: A request with a single active lane produces one full-segment transaction, provided its element does not cross a boundary. The lane mask of that transaction holds only that lane.
- R5: The number of transactions equals the number of distinct segments touched by the active lanes. Each active lane appears in the mask of every segment it touches and in no other mask.
- R6: Transactions are ordered by lane. The next one is chosen by the lowest-numbered lane whose first-byte segment is still pending. Only when no first-byte segment is pending does the lowest lane with a pending last-byte segment choose.
- R7: req_esize code n means an element of n+1 bytes (0=1, 1=2, 2=3, 3=4 bytes). An element whose last byte falls in the next segment touches both segments.
- R8: Lanes whose req_mask bit is 0 never appear in any lane mask, whatever their address. A request with an all-zero mask produces no transaction, and done is raised in the cycle after acceptance with count 0.
- R9: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_base and tx_lanes hold their values into the next cycle.
- R10: req_ready is 0 from the cycle after acceptance until done has been shown. No request offered during that time affects the transactions of the current request.
- R11: done is a one-cycle pulse in the cycle after the last transaction is accepted. done_count equals the number of transactions produced for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | LANES*AW | Byte address per lane, lane i in bits [i*AW +: AW] |
| req_mask | input | LANES | Active lanes |
| req_esize | input | 2 | Element size code, bytes = code+1 |
| tx_valid | output | 1 | Segment transaction offered |
| tx_ready | input | 1 | Memory accepts the transaction |
| tx_base | output | AW | Aligned segment base address |
| tx_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | Request finished (one cycle) |
| done_count | output | $clog2(2*LANES+1) | Transactions produced for the request |

## Verification
Several directed patterns each isolate one case. Contiguous elements of every size starting on a segment base must collapse to one transaction. A 128-byte stride must spread across 32 transactions. Two interleaved segments must come out in lane order. A lone active lane must still cost a full fetch. A mask of zeros must produce nothing. An element that straddles a boundary must be counted in both segments. Random requests then mix contiguous runs at odd offsets, small windows spanning a few segments, fully scattered addresses, broadcast to one address, and random masks. Heavy random backpressure exposes any change in an offered transaction while it is stalled. A second request is held on the input throughout, so any early acceptance shows up as corrupted output.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES     = 32,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [LANES*AW-1:0]            req_addr,
  input  logic [LANES-1:0]               req_mask,
  input  logic [1:0]                     req_esize,
  output logic                           tx_valid,
  input  logic                           tx_ready,
  output logic [AW-1:0]                  tx_base,
  output logic [LANES-1:0]               tx_lanes,
  output logic                           done,
  output logic [$clog2(2*LANES+1)-1:0]   done_count
);
  localparam int OFS = $clog2(SEG_BYTES);
  localparam int CW  = $clog2(2*LANES+1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [LANES-1:0] lo_p, hi_p, hit_lo, hit_hi;
  logic [AW-1:0]    lo_b [LANES];
  logic [AW-1:0]    hi_b [LANES];
  logic [AW-1:0]    lo_n [LANES];
  logic [AW-1:0]    hi_n [LANES];
  logic [AW-1:0]    sel;

  wire pending = |{lo_p, hi_p};
  wire take    = req_valid && !busy;
  wire fire    = tx_valid && tx_ready;

  assign req_ready  = !busy;
  assign tx_valid   = busy && pending;
  assign done       = busy && !pending;
  assign done_count = cnt;
  assign tx_base    = sel;
  assign tx_lanes   = hit_lo | hit_hi;

  function automatic logic [AW-1:0] seg_of(input logic [AW-1:0] a);
    seg_of = {a[AW-1:OFS], {OFS{1'b0}}};
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [AW-1:0] first = req_addr[i*AW +: AW];
    wire [AW-1:0] last  = first + AW'(req_esize);
    assign lo_n[i]   = seg_of(first);
    assign hi_n[i]   = seg_of(last);
    assign hit_lo[i] = lo_p[i] && (lo_b[i] == sel);
    assign hit_hi[i] = hi_p[i] && (hi_b[i] == sel);
  end

  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (hi_p[i]) sel = hi_b[i];
    for (int i = LANES - 1; i >= 0; i--)
      if (lo_p[i]) sel = lo_b[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_p <= '0;
      hi_p <= '0;
      for (int i = 0; i < LANES; i++) begin
        lo_b[i] <= '0;
        hi_b[i] <= '0;
      end
    end else if (take) begin
      for (int i = 0; i < LANES; i++) begin
        lo_b[i] <= lo_n[i];
        hi_b[i] <= hi_n[i];
        lo_p[i] <= req_mask[i];
        hi_p[i] <= req_mask[i] && (hi_n[i] != lo_n[i]);
      end
    end else if (fire) begin
      lo_p <= lo_p & ~hit_lo;
      hi_p <= hi_p & ~hit_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (fire) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES     = 32,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_mask,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [AW-1:0]    tx_base,
  input logic [LANES-1:0] tx_lanes,
  input logic             done
);
  localparam int OFS = $clog2(SEG_BYTES);

  logic [LANES-1:0] act;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act <= '0;
    else if (req_valid && req_ready) act <= req_mask;

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_base[OFS-1:0] == '0); // R2
  AST_LANES_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_lanes != '0); // R5
  AST_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_lanes & ~act) == '0); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) && $stable(tx_lanes)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || done) |-> !req_ready); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !done || act == '0); // R8
endmodule

bind warp_coalescer warp_coalescer_chk #(.LANES(LANES), .AW(AW), .SEG_BYTES(SEG_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_base(tx_base), .tx_lanes(tx_lanes), .done(done)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int LANES  = 32;
  localparam int AW     = 32;
  localparam int SEGB   = 128;
  localparam int CW     = $clog2(2*LANES+1);
  localparam int CLK_NS = 10;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  req_valid = 1'b0;
  logic                  req_ready;
  logic [LANES*AW-1:0]   req_addr = '0;
  logic [LANES-1:0]      req_mask = '0;
  logic [1:0]            req_esize = '0;
  logic                  tx_valid;
  logic                  tx_ready = 1'b0;
  logic [AW-1:0]         tx_base;
  logic [LANES-1:0]      tx_lanes;
  logic                  done;
  logic [CW-1:0]         done_count;

  warp_coalescer #(.LANES(LANES), .AW(AW), .SEG_BYTES(SEGB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .req_esize(req_esize),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_base(tx_base), .tx_lanes(tx_lanes),
    .done(done), .done_count(done_count)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0;
  int bad = 0;

  logic [AW-1:0]    la [LANES];
  logic [LANES-1:0] lm;
  logic [1:0]       les;
  logic [AW-1:0]    exp_base [2*LANES];
  logic [LANES-1:0] exp_mask [2*LANES];
  int               exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] segb(input logic [AW-1:0] a);
    return a & ~AW'(SEGB - 1);
  endfunction

  task automatic build_expect();
    logic [AW-1:0] lb [LANES];
    logic [AW-1:0] hb [LANES];
    logic [LANES-1:0] lp, hp, ml, mh;
    logic [AW-1:0] s;
    bit found;
    for (int i = 0; i < LANES; i++) begin
      lb[i] = segb(la[i]);
      hb[i] = segb(la[i] + AW'(les));
      lp[i] = lm[i];
      hp[i] = lm[i] && (hb[i] != lb[i]);
    end
    exp_n = 0;
    while ((lp | hp) != '0) begin
      found = 0;
      s = '0;
      for (int i = 0; i < LANES; i++)
        if (!found && lp[i]) begin s = lb[i]; found = 1; end
      for (int i = 0; i < LANES; i++)
        if (!found && hp[i]) begin s = hb[i]; found = 1; end
      for (int i = 0; i < LANES; i++) begin
        ml[i] = lp[i] && lb[i] == s;
        mh[i] = hp[i] && hb[i] == s;
      end
      exp_base[exp_n] = s;
      exp_mask[exp_n] = ml | mh;
      exp_n++;
      lp = lp & ~ml;
      hp = hp & ~mh;
    end
  endtask

  task automatic run_req(input string tag, input int stall_pct);
    int idx, cyc, last_hs;
    bit prev_stall, fin;
    logic [AW-1:0] pb;
    logic [LANES-1:0] pl;
    build_expect();
    @(negedge clk);
    check(req_ready === 1'b1, "R10", "ready when idle", 64'(req_ready), 64'd1);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = la[i];
    req_mask  = lm;
    req_esize = les;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = $urandom;
    req_mask = '1;
    req_esize = 2'($urandom);
    idx = 0; cyc = 1; last_hs = 0; prev_stall = 0; fin = 0; pb = '0; pl = '0;
    while (!fin && cyc < 2000) begin
      if (done === 1'b1) begin
        req_valid = 1'b0;
        fin = 1;
        check(32'(done_count) == exp_n, "R11", {tag, " done_count"}, 64'(done_count), 64'(exp_n));
        check(idx == exp_n, "R5", {tag, " transaction total"}, 64'(idx), 64'(exp_n));
        if (exp_n == 0)
          check(cyc == 1, "R8", {tag, " empty request done cycle"}, 64'(cyc), 64'd1);
        else
          check(cyc == last_hs + 1, "R11", {tag, " done timing"}, 64'(cyc), 64'(last_hs + 1));
      end else begin
        if (req_ready !== 1'b0)
          check(0, "R10", {tag, " ready while busy"}, 64'(req_ready), 64'd0);
        if (prev_stall)
          check(tx_valid === 1'b1 && tx_base == pb && tx_lanes == pl, "R9",
                {tag, " stalled offer changed"}, {tx_base, tx_lanes}, {pb, pl});
        tx_ready = ($urandom % 100) >= stall_pct;
        if (tx_valid === 1'b1 && tx_ready) begin
          if (idx >= exp_n) begin
            check(0, tag, "extra transaction", 64'(tx_base), 64'(exp_n));
          end else begin
            check(tx_base == exp_base[idx], tag, "segment base", 64'(tx_base), 64'(exp_base[idx]));
            check(tx_lanes == exp_mask[idx], tag, "lane mask", 64'(tx_lanes), 64'(exp_mask[idx]));
          end
          idx++;
          last_hs = cyc;
        end
        prev_stall = tx_valid === 1'b1 && !tx_ready;
        pb = tx_base;
        pl = tx_lanes;
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) begin
      req_valid = 1'b0;
      check(0, "R11", {tag, " done never seen"}, 64'(cyc), 64'(exp_n));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R11", "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
    check(tx_valid === 1'b0, "R1", "reset tx_valid", 64'(tx_valid), 64'd0);
    check(done === 1'b0, "R1", "reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && tx_valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
          {req_ready, tx_valid, done}, 64'b100);

    // R3 R7: contiguous runs of every element size, one segment
    for (int s = 0; s < 4; s++) begin
      les = 2'(s);
      lm = '1;
      for (int i = 0; i < LANES; i++) la[i] = 32'h0000_1000 + AW'(i * (s + 1));
      run_req("R3", 30);
      check(exp_n == 1, "R3", "model single segment", 64'(exp_n), 64'd1);
    end

    // R4: one active lane, others scattered
    les = 2'd3;
    lm = 32'h0002_0000;
    for (int i = 0; i < LANES; i++) la[i] = $urandom & ~32'h3;
    run_req("R4", 20);

    // R8: nothing active
    lm = '0;
    run_req("R8", 0);

    // R8: inactive lanes with wild addresses
    lm = 32'h0000_00FF;
    for (int i = 0; i < LANES; i++) la[i] = (i < 8) ? 32'h400 + AW'(i) : $urandom;
    les = 2'd0;
    run_req("R8", 10);

    // R5: stride of a full segment
    les = 2'd3;
    lm = '1;
    for (int i = 0; i < LANES; i++) la[i] = 32'h0001_0000 + AW'(i * SEGB);
    run_req("R5", 40);

    // R6: interleaved segments, higher one first in lane 0
    for (int i = 0; i < LANES; i++) la[i] = (i % 2 == 0) ? 32'h900 + AW'(i) : 32'h200 + AW'(i);
    les = 2'd0;
    run_req("R6", 25);

    // R7: element crossing a boundary
    les = 2'd3;
    lm = 32'h3;
    la[0] = 32'h7E;
    la[1] = 32'h80;
    run_req("R7", 0);
    lm = 32'h1;
    run_req("R7", 50);

    // R9: heavy backpressure
    les = 2'd1;
    lm = '1;
    for (int i = 0; i < LANES; i++) la[i] = $urandom % 2048;
    run_req("R9", 85);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int mode;
      logic [AW-1:0] b;
      mode = $urandom % 4;
      les = 2'($urandom);
      lm = ($urandom % 3 == 0) ? $urandom : '1;
      b = $urandom;
      for (int i = 0; i < LANES; i++) begin
        case (mode)
          0: la[i] = b + AW'(i * (int'(les) + 1));
          1: la[i] = b + AW'($urandom % 512);
          2: la[i] = $urandom;
          default: la[i] = b;
        endcase
      end
      run_req("R5", $urandom % 60);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule